// File: doc/BRIEF.md
# Quasi-Bidirectional Latched Parallel Port

This block is one parallel port of a small controller. Each bit has an output latch that holds the last value the bus side stored in it. The bus side changes that latch in one of three ways: a whole-byte write, a set or clear of a single bit, or an AND, OR or XOR with a byte operand. Every modifying operation works on the latch contents and never on the level the pin shows. Two read paths are visible at all times. One returns the latch. The other returns the pin levels after a two-stage synchronizer.

In plain port mode a pin is driven in a quasi-bidirectional way. A latch 0 turns on a strong low driver. A latch 1 turns on only a weak pull-up, so circuitry outside the chip can still pull the pin low. To use a bit as an input, software stores a 1 in it and then reads the pin path. When the alternate-function select is high, an external bus engine takes over the pins as a true push-pull port. That engine supplies an output enable and a value per bit. With the enable low, every driver is off and the pin floats. The latch keeps accepting operations while the engine owns the pins, and it takes the pins back as soon as the select drops.

Top module: `qbp_port`

## Requirements
- R1: After reset every latch bit reads 1. Every pin is released to the weak pull-up, with the low and strong-high drivers off, and the pin read path returns all ones.
- R2: Op code 0 (write) with `op_valid` high loads `op_data` into the latch at the clock edge.
- R3: Op code 1 (set) forces the latch bit selected by `op_bit` to 1, and op code 2 (clear) forces it to 0. All other bits keep their value.
- R4: Op codes 3, 4 and 5 replace the latch with latch AND, OR or XOR `op_data`. The operand is the latch value even when a pin is held low from outside.
- R5: `rd_latch` always returns the latch contents, whatever level the pins show.
- R6: `rd_pin` returns `pin_in` as it was two clock edges earlier.
- R7: With `alt_en` low, a bit has its low driver on exactly when its latch bit is 0, and its pull-up on exactly when the latch bit is 1. The strong-high driver is never on, so a pin is never left floating.
- R8: With `alt_en` high, the pull-ups are off. Each bit drives strong high when `alt_oe` and `alt_out` are both 1, drives low when `alt_oe` is 1 and `alt_out` is 0, and leaves the pin undriven when `alt_oe` is 0.
- R9: Operations issued while `alt_en` is high still update the latch. When `alt_en` falls, the pins follow the latch again.
- R10: With `op_valid` low, or with op code 6 or 7, the latch does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation: 0 write, 1 set, 2 clear, 3 AND, 4 OR, 5 XOR, 6/7 none |
| op_data | input | 8 | Byte operand for write, AND, OR and XOR |
| op_bit | input | 3 | Bit index for set and clear |
| rd_latch | output | 8 | Latch read path |
| rd_pin | output | 8 | Synchronized pin read path |
| alt_en | input | 1 | Alternate-function ownership of the pins |
| alt_oe | input | 8 | Per-bit output enable from the bus engine |
| alt_out | input | 8 | Per-bit output value from the bus engine |
| pin_in | input | 8 | Resolved pin levels |
| drv_low | output | 8 | Strong low driver enable |
| drv_high | output | 8 | Strong high driver enable |
| pullup_en | output | 8 | Weak pull-up enable |

## Verification
The bench connects the drive outputs to a pin model that has an external pull-down per bit and a random level for pins that float. Random streams of all eight op codes run with random pull-downs. Read-modify-write operations on bits that are held low tell a latch-based update apart from a pin-based one. Random alternate-function enables and values, some of them given while operations are issued, separate the two drive modes and show whether the latch is still updated underneath. A directed step on a single pin measures the two-cycle read-pin delay.

// File: rtl/qbp_pkg.sv
// Package: shared operation encoding for the quasi-bidirectional port.
// Assumes: op codes 6 and 7 are reserved and have no effect.
package qbp_pkg;
    typedef enum logic [2:0] {
        OP_WRITE = 3'd0,
        OP_SET   = 3'd1,
        OP_CLR   = 3'd2,
        OP_AND   = 3'd3,
        OP_OR    = 3'd4,
        OP_XOR   = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } qbp_op_e;
endpackage

// File: rtl/qbp_latch.sv
// Module: output latch with byte, bit and read-modify-write updates.
// Assumes: every update takes the current latch value as its operand and
// never the pin level; reset loads all ones (pins released).
module qbp_latch #(
    parameter int W  = 8,
    parameter int BW = (W > 1) ? $clog2(W) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  qbp_pkg::qbp_op_e     op_code,
    input  logic [W-1:0]         op_data,
    input  logic [BW-1:0]        op_bit,
    output logic [W-1:0]         latch_q
);
    import qbp_pkg::*;

    logic [W-1:0] bit_mask;
    logic [W-1:0] latch_d;

    // Build a one-hot mask for the selected bit.
    always_comb begin
        bit_mask = '0;
        for (int i = 0; i < W; i++) begin
            if (BW'(i) == op_bit) bit_mask[i] = 1'b1;
        end
    end

    // Compute the next latch value from the current latch contents.
    always_comb begin
        latch_d = latch_q;
        if (op_valid) begin
            case (op_code)
                OP_WRITE: latch_d = op_data;
                OP_SET:   latch_d = latch_q | bit_mask;
                OP_CLR:   latch_d = latch_q & ~bit_mask;
                OP_AND:   latch_d = latch_q & op_data;
                OP_OR:    latch_d = latch_q | op_data;
                OP_XOR:   latch_d = latch_q ^ op_data;
                default:  latch_d = latch_q;
            endcase
        end
    end

    // Hold the latch; reset releases every pin.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '1;
        else        latch_q <= latch_d;
    end
endmodule

// File: rtl/qbp_sync.sv
// Module: multi-stage synchronizer for the pin read path.
// Assumes: pins are asynchronous; stages reset to 1 to match released pins.
module qbp_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pin levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '1;
                    else        stage_q[0] <= d;
                end
            end else begin : g_next
                // Pass the value along one more stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '1;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/qbp_drive.sv
// Module: per-bit pin driver control.
// Assumes: in plain mode the latch drives (strong low or weak high only);
// in alternate mode the bus engine drives push-pull or floats the pin.
module qbp_drive #(
    parameter int W = 8
) (
    input  logic         alt_en,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] alt_oe,
    input  logic [W-1:0] alt_out,
    output logic [W-1:0] drv_low,
    output logic [W-1:0] drv_high,
    output logic [W-1:0] pullup_en
);
    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            // Choose the driver set for this bit from the active mode.
            always_comb begin
                if (alt_en) begin
                    drv_low[b]   = alt_oe[b] & ~alt_out[b];
                    drv_high[b]  = alt_oe[b] &  alt_out[b];
                    pullup_en[b] = 1'b0;
                end else begin
                    drv_low[b]   = ~latch_q[b];
                    drv_high[b]  = 1'b0;
                    pullup_en[b] =  latch_q[b];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/qbp_port.sv
// Module: top of the quasi-bidirectional latched port.
// Assumes: one operation per cycle; pins are resolved outside and come
// back on pin_in.
module qbp_port #(
    parameter int W       = 8,
    parameter int BW      = (W > 1) ? $clog2(W) : 1,
    parameter int SYNC_ST = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    input  logic [W-1:0]  op_data,
    input  logic [BW-1:0] op_bit,
    output logic [W-1:0]  rd_latch,
    output logic [W-1:0]  rd_pin,
    input  logic          alt_en,
    input  logic [W-1:0]  alt_oe,
    input  logic [W-1:0]  alt_out,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  drv_low,
    output logic [W-1:0]  drv_high,
    output logic [W-1:0]  pullup_en
);
    import qbp_pkg::*;

    logic [W-1:0] latch_q;

    qbp_latch #(.W(W), .BW(BW)) i_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (qbp_op_e'(op_code)),
        .op_data  (op_data),
        .op_bit   (op_bit),
        .latch_q  (latch_q)
    );

    qbp_sync #(.W(W), .STAGES(SYNC_ST)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (rd_pin)
    );

    qbp_drive #(.W(W)) i_drive (
        .alt_en    (alt_en),
        .latch_q   (latch_q),
        .alt_oe    (alt_oe),
        .alt_out   (alt_out),
        .drv_low   (drv_low),
        .drv_high  (drv_high),
        .pullup_en (pullup_en)
    );

    assign rd_latch = latch_q;
endmodule

// File: rtl/qbp_port_chk.sv
// Module: assertion checker bound to qbp_port.
// Assumes: the default two-stage synchronizer.
module qbp_port_chk #(
    parameter int W  = 8,
    parameter int BW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [2:0]    op_code,
    input logic [W-1:0]  op_data,
    input logic [BW-1:0] op_bit,
    input logic [W-1:0]  rd_latch,
    input logic [W-1:0]  rd_pin,
    input logic          alt_en,
    input logic [W-1:0]  alt_oe,
    input logic [W-1:0]  alt_out,
    input logic [W-1:0]  pin_in,
    input logic [W-1:0]  drv_low,
    input logic [W-1:0]  drv_high,
    input logic [W-1:0]  pullup_en
);
    logic [1:0] cyc;

    // Count cycles since reset, saturating, to guard the two-cycle lookback.
    always_ff @(posedge clk) begin
        if (!rst_n)        cyc <= '0;
        else if (cyc != 3) cyc <= cyc + 2'd1;
    end

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd0) |=> rd_latch == $past(op_data)); // R2
    AST_PLAIN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_en |-> (drv_low == ~rd_latch && drv_high == '0)); // R7
    AST_ALT_NO_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
        alt_en |-> (pullup_en == '0 && (drv_low & drv_high) == '0)); // R8
    AST_PIN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2) |-> rd_pin == $past(pin_in, 2)); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code[2:1] == 2'b11) |=> $stable(rd_latch)); // R10
endmodule

bind qbp_port qbp_port_chk #(.W(W), .BW(BW)) i_chk (.*);

// File: tb/test_qbp_port.sv
module test_qbp_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = '0;
    logic [7:0] op_data = '0;
    logic [2:0] op_bit = '0;
    logic [7:0] rd_latch, rd_pin;
    logic       alt_en = 1'b0;
    logic [7:0] alt_oe = '0, alt_out = '0;
    logic [7:0] pin_in;
    logic [7:0] drv_low, drv_high, pullup_en;
    logic [7:0] ext_pd = '0;   // external pull-downs
    logic [7:0] flt = '0;      // level seen by floating pins
    logic [7:0] m_latch;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    qbp_port i_qbp_port (.*);

    // Resolve each pin: strong drivers, then external pull-down, then pull-up.
    always_comb begin
        for (int i = 0; i < 8; i++) begin
            if (drv_low[i])        pin_in[i] = 1'b0;
            else if (drv_high[i])  pin_in[i] = 1'b1;
            else if (ext_pd[i])    pin_in[i] = 1'b0;
            else if (pullup_en[i]) pin_in[i] = 1'b1;
            else                   pin_in[i] = flt[i];
        end
    end

    function automatic logic [7:0] f_apply(logic [7:0] l, logic [2:0] c,
                                           logic [7:0] d, logic [2:0] b);
        case (c)
            3'd0: return d;
            3'd1: return l | (8'd1 << b);
            3'd2: return l & ~(8'd1 << b);
            3'd3: return l & d;
            3'd4: return l | d;
            3'd5: return l ^ d;
            default: return l;
        endcase
    endfunction

    function automatic logic [23:0] f_drv(logic [7:0] l, logic a,
                                          logic [7:0] oe, logic [7:0] o);
        if (a) return {oe & ~o, oe & o, 8'h00};
        return {~l, 8'h00, l};
    endfunction

    function automatic logic [7:0] f_pin(logic [23:0] d, logic [7:0] pd,
                                         logic [7:0] f);
        logic [7:0] p;
        for (int i = 0; i < 8; i++) begin
            if (d[16+i])     p[i] = 1'b0;
            else if (d[8+i]) p[i] = 1'b1;
            else if (pd[i])  p[i] = 1'b0;
            else if (d[i])   p[i] = 1'b1;
            else             p[i] = f[i];
        end
        return p;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_drive(string tag);
        chk(tag, {8'h0, drv_low, drv_high, pullup_en},
            {8'h0, f_drv(m_latch, alt_en, alt_oe, alt_out)});
    endtask

    // Issue one operation; returns at the negedge after it took effect.
    task automatic do_op(logic [2:0] c, logic [7:0] d, logic [2:0] b, logic v);
        @(negedge clk);
        op_valid = v; op_code = c; op_data = d; op_bit = b;
        @(negedge clk);
        op_valid = 1'b0;
        if (v) m_latch = f_apply(m_latch, c, d, b);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        m_latch = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 latch", rd_latch, 8'hFF);
        chk("R1 pin", rd_pin, 8'hFF);
        chk_drive("R1 drive");

        // R2 write
        do_op(3'd0, 8'hA5, 3'd0, 1'b1);
        chk("R2 write", rd_latch, 8'hA5);
        chk_drive("R7 plain drive after write");
        // R3 set and clear
        do_op(3'd1, 8'h00, 3'd1, 1'b1);
        chk("R3 set bit1", rd_latch, 8'hA7);
        do_op(3'd2, 8'hFF, 3'd7, 1'b1);
        chk("R3 clear bit7", rd_latch, 8'h27);

        // R4/R5 pins held low outside, RMW must use latch
        do_op(3'd0, 8'hFF, 3'd0, 1'b1);
        @(negedge clk); ext_pd = 8'h0F;
        repeat (3) @(negedge clk);
        chk("R5 pin path sees pull-down", rd_pin, 8'hF0);
        chk("R5 latch path ignores pins", rd_latch, 8'hFF);
        do_op(3'd4, 8'h00, 3'd0, 1'b1);
        chk("R4 OR from latch", rd_latch, 8'hFF);
        do_op(3'd5, 8'h01, 3'd0, 1'b1);
        chk("R4 XOR from latch", rd_latch, 8'hFE);
        do_op(3'd3, 8'hF3, 3'd0, 1'b1);
        chk("R4 AND from latch", rd_latch, 8'hF2);
        do_op(3'd1, 8'h00, 3'd0, 1'b1);
        chk("R3 set from latch", rd_latch, 8'hF3);

        // R10 idle and reserved codes
        do_op(3'd0, 8'h00, 3'd0, 1'b0);
        chk("R10 no valid", rd_latch, 8'hF3);
        do_op(3'd6, 8'h00, 3'd0, 1'b1);
        chk("R10 code6", rd_latch, 8'hF3);
        do_op(3'd7, 8'h00, 3'd0, 1'b1);
        chk("R10 code7", rd_latch, 8'hF3);

        // R6 two-cycle pin delay
        do_op(3'd0, 8'hFF, 3'd0, 1'b1);
        @(negedge clk); ext_pd = 8'h00;
        repeat (3) @(negedge clk);
        chk("R6 settled", rd_pin, 8'hFF);
        ext_pd = 8'h01;
        @(negedge clk);
        chk("R6 one edge", rd_pin, 8'hFF);
        @(negedge clk);
        chk("R6 two edges", rd_pin, 8'hFE);
        ext_pd = 8'h00;

        // R8 alternate mode, R9 latch updates underneath
        alt_en = 1'b1; alt_oe = 8'hF0; alt_out = 8'hCC; flt = 8'h05;
        do_op(3'd0, 8'h5A, 3'd0, 1'b1);
        chk("R9 latch in alt", rd_latch, 8'h5A);
        chk_drive("R8 alt drive");
        repeat (2) @(negedge clk);
        chk("R8 alt pins hiz float", rd_pin, 8'hC5);
        alt_en = 1'b0;
        @(negedge clk);
        chk_drive("R9 back to latch");
        repeat (2) @(negedge clk);
        chk("R9 pins follow latch", rd_pin, 8'h5A);

        // Random mix
        for (int it = 0; it < 300; it++) begin
            logic [2:0] c = 3'($urandom);
            logic [7:0] d = 8'($urandom);
            logic [2:0] b = 3'($urandom);
            logic       v = ($urandom % 8) != 0;
            @(negedge clk);
            ext_pd  = 8'($urandom) & 8'($urandom);
            alt_en  = ($urandom % 4) == 0;
            alt_oe  = 8'($urandom);
            alt_out = 8'($urandom);
            flt     = 8'($urandom);
            do_op(c, d, b, v);
            chk("R2/R3/R4/R10 random latch", rd_latch, m_latch);
            chk_drive(alt_en ? "R8 random drive" : "R7 random drive");
            if (!alt_en)
                chk("R7 never floats", drv_low | pullup_en, 8'hFF);
            repeat (2) @(negedge clk);
            chk("R6 random pin",
                rd_pin, f_pin(f_drv(m_latch, alt_en, alt_oe, alt_out), ext_pd, flt));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule